// File: doc/BRIEF.md
# Memory-mapped cycle counter for a local bus

A read-only slave for a synchronous bus with a single master. It holds a free-running up-counter that steps by one on every clock. The master reads the counter through a small window of the address map. The slave sees the raw address, so it claims its window itself. It does this with a mask-and-compare, and the mask and compare values are worked out from the base and high address parameters. Only the address bits that differ across the window are ignored. Every other bit must match the base.

Each request lasts a single cycle. The slave registers everything it needs at the strobe edge. It answers one cycle later with a one-cycle ready pulse and the read data, and it never stretches a transfer. All slaves on the bus OR their ready and data lines together. For that reason this slave keeps ready and read data at zero in every cycle in which it is not completing one of its own transfers. Writes are acknowledged but change nothing.

On a 32-bit data bus, address bit 2 picks the counter half. On a 64-bit data bus, the whole counter is returned.

Top module: `lbcc_top`

## Requirements
- R1: While `rst` is high, `ready` and `rd_data` are 0. The counter is loaded with `RESET_VALUE`, so the first strobe after the reset is released returns the low word of `RESET_VALUE`.
- R2: A request is a cycle with `addr_strobe` high and `(addr & MASK) == (BASE_ADDR & MASK)`, where `MASK = ~(BASE_ADDR ^ HIGH_ADDR)`. For each request, `ready` is high in exactly the following cycle.
- R3: When there is no request in a cycle, `ready` and `rd_data` are 0 in the following cycle. This covers an idle strobe and an address outside the window.
- R4: A read request with address bit 2 = 0 returns counter bits 31:0. The value is the one the counter held at the strobe clock edge.
- R5: A read request with address bit 2 = 1 returns counter bits 63:32 of that same value, including across a carry out of the low word.
- R6: The counter increases by exactly one on every clock after reset. Two reads on consecutive cycles therefore return values that differ by 1.
- R7: A request with `rd_strobe` = 0 is a write. It gets `ready` but returns `rd_data` = 0 and leaves the counter sequence unchanged.
- R8: Address bits covered by the window are ignored apart from bit 2. For example, base+8 aliases base+0 and base+0xFFC reads the high word. An address that differs from the base in one masked bit is not claimed.
- R9: Requests on consecutive cycles are each acknowledged, with `ready` held high and no wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe | input | 1 | Request valid in this cycle only |
| rd_strobe | input | 1 | High for a read, low for a write |
| addr | input | ADDR_W | Raw byte address |
| rd_data | output | DATA_W | Read data, zero outside own acknowledge |
| ready | output | 1 | One-cycle acknowledge of own requests |

## Verification
The bench releases reset with the counter loaded just below a low-word carry. Reads of the high word right around the carry then catch a design that latches the halves at different times or selects the wrong half. It drives strobes whose address misses the window by one high bit, and idle cycles with a valid address on the bus. A loose decoder would answer these, and a slave that leaks data while idle would show up here as non-zero data. Back-to-back reads, writes between reads and aliased offsets check the remaining behaviour. A slave that samples late, stalls, or lets a write disturb the count returns values off by one or more from the scoreboard.

// File: rtl/lbcc_pkg.sv
`timescale 1ns/1ps
package lbcc_pkg;
  // Request decoded in the strobe cycle
  typedef struct packed {
    logic hit;   // address inside own window
    logic rd;    // read transfer
    logic sel;   // upper counter half selected
  } lbcc_req_t;
endpackage

// File: rtl/lbcc_decode.sv
`timescale 1ns/1ps
module lbcc_decode
  import lbcc_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0000_2000,
  parameter logic [31:0] HIGH_ADDR = 32'h0000_2FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_strobe,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] addr,
  output lbcc_req_t         req_d,
  output logic              ack_q
);
  localparam logic [ADDR_W-1:0] MASK  = ADDR_W'(~(BASE_ADDR ^ HIGH_ADDR));
  localparam logic [ADDR_W-1:0] CHECK = ADDR_W'(BASE_ADDR) & MASK;
  localparam int                SEL_BIT = $clog2(DATA_W / 8);

  logic in_win;
  assign in_win = ((addr & MASK) == CHECK);

  always_comb begin
    req_d.hit = addr_strobe && in_win;
    req_d.rd  = addr_strobe && in_win && rd_strobe;
  end

  generate
    if (DATA_W == 32) begin : g_narrow
      assign req_d.sel = addr[SEL_BIT];
    end else begin : g_wide
      assign req_d.sel = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= req_d.hit;
  end

  // R2: a request in the window is acknowledged in the next cycle
  p_ack_on_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (addr_strobe && in_win) |=> ack_q);

  // R3: no strobe means silence in the next cycle
  p_idle_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (!addr_strobe) |=> !ack_q);
endmodule

// File: rtl/lbcc_counter.sv
`timescale 1ns/1ps
module lbcc_counter #(
  parameter int             CNT_W       = 64,
  parameter logic [CNT_W-1:0] RESET_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= RESET_VALUE;
    else     cnt <= cnt + CNT_W'(1);
  end

  // R6: steps by one on every clock
  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/lbcc_rdmux.sv
`timescale 1ns/1ps
module lbcc_rdmux
  import lbcc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  lbcc_req_t         req_d,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word;
  assign word = req_d.sel ? cnt[CNT_W-1 -: DATA_W] : cnt[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)           rd_data <= '0;
    else if (req_d.rd) rd_data <= word;
    else               rd_data <= '0;
  end
endmodule

// File: rtl/lbcc_top.sv
`timescale 1ns/1ps
module lbcc_top
  import lbcc_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter int               DATA_W      = 32,
  parameter int               CNT_W       = 64,
  parameter logic [31:0]      BASE_ADDR   = 32'h0000_2000,
  parameter logic [31:0]      HIGH_ADDR   = 32'h0000_2FFF,
  parameter logic [CNT_W-1:0] RESET_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_strobe,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready
);
  lbcc_req_t        req_d;
  logic [CNT_W-1:0] cnt;

  lbcc_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BASE_ADDR(BASE_ADDR), .HIGH_ADDR(HIGH_ADDR)
  ) u_decode (
    .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .rd_strobe(rd_strobe),
    .addr(addr), .req_d(req_d), .ack_q(ready)
  );

  lbcc_counter #(.CNT_W(CNT_W), .RESET_VALUE(RESET_VALUE)) u_counter (
    .clk(clk), .rst(rst), .cnt(cnt)
  );

  lbcc_rdmux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rdmux (
    .clk(clk), .rst(rst), .req_d(req_d), .cnt(cnt), .rd_data(rd_data)
  );

  // R3: data lines stay quiet whenever this slave is not acknowledging
  p_quiet_data_r3: assert property (@(posedge clk) disable iff (rst)
    (!ready) |-> (rd_data == '0));

  // R7: a write returns no data
  p_write_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (addr_strobe && !rd_strobe) |=> (rd_data == '0));
endmodule

// File: tb/lbcc_top_bench.sv
`timescale 1ns/1ps
module lbcc_top_bench;
  localparam logic [63:0] RST_VAL = 64'h0000_0000_FFFF_FFF0;
  localparam logic [31:0] BASE    = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_strobe = 1'b0;
  logic        rd_strobe = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] rd_data;
  logic        ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        rdy;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [63:0] tb_cnt;

  always #2.5 clk = ~clk;

  lbcc_top #(
    .BASE_ADDR(BASE), .HIGH_ADDR(32'h0000_2FFF), .RESET_VALUE(RST_VAL)
  ) u_lbcc_top (
    .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .rd_strobe(rd_strobe),
    .addr(addr), .rd_data(rd_data), .ready(ready)
  );

  // Reference counter from R1/R6
  always @(posedge clk) begin
    if (rst) tb_cnt <= RST_VAL;
    else     tb_cnt <= tb_cnt + 64'd1;
  end

  task automatic drive(input logic as, input logic rd, input logic [31:0] a,
                       input string tag);
    exp_t e;
    logic hit;
    @(negedge clk);
    addr_strobe = as;
    rd_strobe   = rd;
    addr        = a;
    hit         = as && ((a & 32'hFFFF_F000) == 32'h0000_2000);
    e.rdy  = hit;
    e.data = (hit && rd) ? (a[2] ? tb_cnt[63:32] : tb_cnt[31:0]) : 32'h0;
    e.tag  = tag;
    q.push_back(e);
  endtask

  // Monitor: one expectation per cycle after reset
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (ready !== e.rdy || rd_data !== e.data) begin
        errors++;
        $display("FAIL %s: ready=%b rd_data=%h expected ready=%b rd_data=%h",
                 e.tag, ready, rd_data, e.rdy, e.data);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: silent during reset, even with a valid request on the bus
    repeat (2) @(negedge clk);
    addr_strobe = 1'b1; rd_strobe = 1'b1; addr = BASE;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (ready !== 1'b0 || rd_data !== 32'h0) begin
        errors++;
        $display("FAIL R1: ready=%b rd_data=%h expected ready=0 rd_data=0",
                 ready, rd_data);
      end
    end
    addr_strobe = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    // R1: first read returns low word of the reset value
    q.push_back('{rdy: 1'b1, data: RST_VAL[31:0], tag: "R1"});
    addr_strobe = 1'b1; rd_strobe = 1'b1; addr = BASE;
    // R6/R9: back-to-back low reads
    drive(1, 1, BASE, "R6");
    drive(1, 1, BASE, "R9");
    // R3: idle and outside-window cycles
    drive(0, 1, BASE, "R3");
    drive(1, 1, 32'h0000_3000, "R8");
    drive(1, 1, 32'h1000_2000, "R8");
    drive(0, 0, 32'h0, "R3");
    // R7: write then read; sequence must continue
    drive(1, 0, BASE, "R7");
    drive(1, 0, BASE + 32'h4, "R7");
    drive(1, 1, BASE, "R7");
    // R8: aliases inside the window
    drive(1, 1, BASE + 32'h8, "R8");
    drive(1, 1, BASE + 32'hFFC, "R8");
    // R4/R5: walk across the low-word carry alternating halves
    for (int i = 0; i < 16; i++) begin
      drive(1, 1, BASE + 32'h4, "R5");
      drive(1, 1, BASE, "R4");
      if (i % 3 == 0) drive(0, 1, BASE + 32'h4, "R3");
    end
    // R2: isolated request yields a single ready pulse
    drive(1, 1, BASE + 32'h4, "R2");
    drive(0, 1, BASE, "R2");
    drive(0, 1, BASE, "R3");
    @(negedge clk);
    addr_strobe = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule